// File: doc/BRIEF.md
# Freeze Entry Sequencer With Timeout

This block runs the freeze entry procedure of a CAN controller for a host. The block never waits forever for the controller. A single start pulse makes it store the control word that the host wants restored later. It then requests freeze and halt together. If the controller reports that it is disabled, the block clears the disable. It then waits for the freeze acknowledge, which the controller holds back while the bus is busy or stuck dominant.

The wait is limited to a budget of bit-time ticks. The default budget of 140 ticks covers the longest frame, the intermission and the internal latency. If the budget runs out, the block issues a soft reset and waits for the reset bit to read back low. It then writes the stored control word back. A second watchdog, counted in clock cycles, stops the soft-reset wait if the bit never clears. The block reports the end of the sequence with a one-cycle done pulse, a recovered flag and an error flag.

The controller is outside the block. The block sees it only through three status inputs and one write strobe. The strobe carries an operation code and, for the restore, a data word.

Top module: `freeze_entry_seq`

## Requirements
- R1: A start pulse taken in idle stores `cfg_i` and raises `busy_o`. In the next cycle the block issues a write with op code 0, which requests freeze and halt together.
- R2: In the cycle after the freeze/halt write, the block issues a write with op code 1 (clear module disable) if `mdis_i` is high. If `mdis_i` is low it issues no write in that cycle.
- R3: While waiting, the block counts `bit_tick_i` pulses. If `frz_ack_i` is high before the count reaches `FRZ_LIMIT`, the sequence ends with `done_o` and with `recovered_o` and `error_o` low. No soft reset or restore write follows.
- R4: If the acknowledge and the expiry of the budget are seen in the same cycle, the acknowledge wins and no soft reset is issued.
- R5: Without an acknowledge, the block issues a write with op code 2 (soft reset) two cycles after the clock edge that samples the `FRZ_LIMIT`-th tick of the wait.
- R6: After the soft reset, the block waits for `softrst_i` to be low. In the next cycle it issues a write with op code 3 (restore) with `wr_data_o` equal to the stored word. `done_o` then follows in the next cycle with `recovered_o` high. `done_o` comes two cycles after the first low sample of `softrst_i`.
- R7: If `softrst_i` stays high, `done_o` comes `RST_LIMIT`+2 cycles after the soft-reset write, with `error_o` high and `recovered_o` low. No restore write is issued.
- R8: A start pulse that arrives while `busy_o` is high is ignored and does not cause a second freeze/halt write.
- R9: `done_o` lasts exactly one cycle. `recovered_o` and `error_o` keep their values until the next accepted start, which clears them.
- R10: After reset the block is idle, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| cfg_i | input | CFG_W | Control word to restore after a soft reset |
| bit_tick_i | input | 1 | One pulse per CAN bit time |
| frz_ack_i | input | 1 | Freeze acknowledge status from the controller |
| mdis_i | input | 1 | Module-disable status from the controller |
| softrst_i | input | 1 | Soft-reset status bit read back from the controller |
| wr_en_o | output | 1 | Control write strobe |
| wr_op_o | output | 2 | Write operation: 0 freeze+halt, 1 clear disable, 2 soft reset, 3 restore |
| wr_data_o | output | CFG_W | Restore data; zero for other operations |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| recovered_o | output | 1 | Last sequence needed the soft-reset path |
| error_o | output | 1 | Last sequence stopped on the soft-reset watchdog |

## Verification
The freeze/halt write is due one cycle after start is sampled, and the optional disable clear comes one cycle later. The soft reset comes two cycles after the edge that samples the last tick of the budget. The restore comes one cycle after the reset bit is first seen low, and done one cycle after that. The stuck case ends `RST_LIMIT`+2 cycles after the reset write. The bench samples every output at the falling edge and numbers the cycles. It counts only the ticks that fall on edges where the wait state is active. It keeps bit ticks at least two cycles apart, so the tick count when the soft reset is seen must equal the budget exactly. It also compares the cycle distances above directly.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    OP_FRZ_HALT = 2'd0,
    OP_CLR_MDIS = 2'd1,
    OP_SOFTRST  = 2'd2,
    OP_RESTORE  = 2'd3
  } fes_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FRZ, ST_MDIS, ST_WAIT, ST_SRST, ST_SRST_WAIT, ST_RESTORE, ST_DONE
  } fes_state_e;
endpackage

// File: rtl/fes_limit_timer.sv
module fes_limit_timer #(
  parameter int LIMIT = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LIM);

  // cleared whenever disabled, saturates at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i)               cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  a_r5_clear_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             frz_ack_i,
  input  logic             mdis_i,
  input  logic             softrst_i,
  input  logic             frz_exp_i,
  input  logic             rst_exp_i,
  output logic             frz_en_o,
  output logic             rst_en_o,
  output logic             wr_en_o,
  output fes_op_e          wr_op_o,
  output logic [CFG_W-1:0] wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             recovered_o,
  output logic             error_o
);
  fes_state_e       state_q, state_d;
  logic [CFG_W-1:0] cfg_q;
  logic             rec_q, err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_FRZ;
      ST_FRZ:       state_d = ST_MDIS;
      ST_MDIS:      state_d = ST_WAIT;
      ST_WAIT:      if (frz_ack_i) state_d = ST_DONE;
                    else if (frz_exp_i) state_d = ST_SRST;
      ST_SRST:      state_d = ST_SRST_WAIT;
      ST_SRST_WAIT: if (!softrst_i) state_d = ST_RESTORE;
                    else if (rst_exp_i) state_d = ST_DONE;
      ST_RESTORE:   state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      rec_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        cfg_q <= cfg_i;
        rec_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (state_q == ST_RESTORE) rec_q <= 1'b1;
      if (state_q == ST_SRST_WAIT && softrst_i && rst_exp_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_op_o   = OP_FRZ_HALT;
    wr_data_o = '0;
    unique case (state_q)
      ST_FRZ:     wr_en_o = 1'b1;
      ST_MDIS:    begin wr_en_o = mdis_i; wr_op_o = OP_CLR_MDIS; end
      ST_SRST:    begin wr_en_o = 1'b1;   wr_op_o = OP_SOFTRST;  end
      ST_RESTORE: begin wr_en_o = 1'b1;   wr_op_o = OP_RESTORE; wr_data_o = cfg_q; end
      default:    ;
    endcase
  end

  assign frz_en_o    = (state_q == ST_WAIT);
  assign rst_en_o    = (state_q == ST_SRST_WAIT);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign recovered_o = rec_q;
  assign error_o     = err_q;

  a_r1_first_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (wr_en_o && wr_op_o == OP_FRZ_HALT && busy_o));

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !(wr_en_o && wr_op_o == OP_FRZ_HALT));

  a_r4_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en_o && frz_ack_i) |=> (done_o && !recovered_o));

  a_r5_reset_after_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_op_o == OP_SOFTRST) |-> ($past(frz_exp_i) && !$past(frz_ack_i)));

  a_r6_restore_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_op_o == OP_RESTORE) |-> (!$past(softrst_i) && $past(rst_en_o)));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_error_excludes_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !recovered_o);
endmodule

// File: rtl/freeze_entry_seq.sv
module freeze_entry_seq
  import fes_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int FRZ_LIMIT = 140,
  parameter int RST_LIMIT = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bit_tick_i,
  input  logic             frz_ack_i,
  input  logic             mdis_i,
  input  logic             softrst_i,
  output logic             wr_en_o,
  output logic [1:0]       wr_op_o,
  output logic [CFG_W-1:0] wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             recovered_o,
  output logic             error_o
);
  logic    frz_en, rst_en, frz_exp, rst_exp;
  fes_op_e op;

  // freeze budget in bit ticks
  fes_limit_timer #(.LIMIT(FRZ_LIMIT)) u_frz_timer (
    .clk_i, .rst_ni, .en_i(frz_en), .tick_i(bit_tick_i), .expired_o(frz_exp)
  );

  // soft-reset watchdog in clock cycles
  fes_limit_timer #(.LIMIT(RST_LIMIT)) u_rst_timer (
    .clk_i, .rst_ni, .en_i(rst_en), .tick_i(1'b1), .expired_o(rst_exp)
  );

  fes_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cfg_i, .frz_ack_i, .mdis_i, .softrst_i,
    .frz_exp_i(frz_exp), .rst_exp_i(rst_exp),
    .frz_en_o(frz_en), .rst_en_o(rst_en),
    .wr_en_o, .wr_op_o(op), .wr_data_o,
    .busy_o, .done_o, .recovered_o, .error_o
  );

  assign wr_op_o = op;

  a_r3_single_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({frz_en, rst_en, done_o}) <= 1);
endmodule

// File: tb/tb_freeze_entry_seq.sv
module tb_freeze_entry_seq;
  localparam int CFG_W = 32;
  localparam int FRZ_LIMIT = 140;
  localparam int RST_LIMIT = 256;
  localparam logic [1:0] OP_FH = 2'd0, OP_CM = 2'd1, OP_SR = 2'd2, OP_RS = 2'd3;
  localparam int OUT_ACK = 0, OUT_REC = 1, OUT_ERR = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CFG_W-1:0] cfg_i = '0;
  logic bit_tick = 1'b0, ack_m = 1'b0, mdis_m = 1'b0, softrst_m = 1'b0;
  logic wr_en_o, busy_o, done_o, recovered_o, error_o;
  logic [1:0] wr_op_o;
  logic [CFG_W-1:0] wr_data_o;

  always #4 clk = ~clk;

  freeze_entry_seq #(.CFG_W(CFG_W), .FRZ_LIMIT(FRZ_LIMIT), .RST_LIMIT(RST_LIMIT)) dut (
    .clk_i(clk), .rst_ni, .start_i, .cfg_i, .bit_tick_i(bit_tick), .frz_ack_i(ack_m),
    .mdis_i(mdis_m), .softrst_i(softrst_m), .wr_en_o, .wr_op_o, .wr_data_o,
    .busy_o, .done_o, .recovered_o, .error_o
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit sc_ack_en = 0, sc_stuck = 0;
  int sc_ack_after = 0, sc_rdur = 1, tdiv = 3, divcnt = 0;
  int phase = -1, tcnt = 0, rst_left = 0;
  bit wait_seen = 0, prev_done = 0;
  int n_frz = 0, n_mdis = 0, n_srst = 0, n_rest = 0, n_done = 0, n_dbl = 0;
  int srst_tcnt = 0, srst_cyc = 0, done_cyc = 0;
  logic [CFG_W-1:0] rest_data = '0;
  bit done_rec = 0, done_err = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_outcome(bit ack_en, int ack_after, bit stuck);
    if (ack_en && ack_after <= FRZ_LIMIT) return OUT_ACK;
    if (stuck) return OUT_ERR;
    return OUT_REC;
  endfunction

  // controller model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (wait_seen && bit_tick) tcnt++;
    if (wr_en_o && wr_op_o == OP_FH) begin n_frz++; phase = 0; end
    else if (phase >= 0) phase++;
    if (phase == 2) begin wait_seen = 1; phase = -1; end
    if (wr_en_o && wr_op_o == OP_CM) begin n_mdis++; mdis_m = 1'b0; end
    if (wr_en_o && wr_op_o == OP_SR) begin
      n_srst++; srst_tcnt = tcnt; srst_cyc = cyc; wait_seen = 0;
      softrst_m = 1'b1; rst_left = sc_rdur;
    end else if (softrst_m && !sc_stuck) begin
      rst_left--;
      if (rst_left <= 0) softrst_m = 1'b0;
    end
    if (wr_en_o && wr_op_o == OP_RS) begin n_rest++; rest_data = wr_data_o; end
    if (done_o) begin
      n_done++; done_cyc = cyc; done_rec = recovered_o; done_err = error_o; wait_seen = 0;
    end
    if (prev_done && done_o) n_dbl++;
    prev_done = done_o;
    if (sc_ack_en && wait_seen && tcnt >= sc_ack_after) ack_m = 1'b1;
    divcnt = (divcnt + 1) % tdiv;
    bit_tick = (divcnt == 0);
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_case(bit mdis0, bit ack_en, int ack_after, bit stuck, int rdur, int td);
    logic [CFG_W-1:0] cfg;
    int oc;
    cfg = $urandom;
    oc = expect_outcome(ack_en, ack_after, stuck);
    @(negedge clk);
    sc_ack_en = ack_en; sc_ack_after = ack_after; sc_stuck = stuck; sc_rdur = rdur; tdiv = td;
    mdis_m = mdis0; ack_m = 1'b0; softrst_m = 1'b0;
    n_frz = 0; n_mdis = 0; n_srst = 0; n_rest = 0; n_done = 0; n_dbl = 0; tcnt = 0;
    cfg_i = cfg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; cfg_i = ~cfg;
    chk(!recovered_o && !error_o, "R9", "flags cleared on start", {recovered_o, error_o}, 0);
    @(negedge clk);
    start_i = 1'b1;  // arrives while busy
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5000 && n_done == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_frz == 1, "R1/R8", "freeze/halt writes", n_frz, 1);
    chk(n_mdis == int'(mdis0), "R2", "clear-disable writes", n_mdis, int'(mdis0));
    chk(n_done == 1 && n_dbl == 0, "R9", "done pulses", n_done * 10 + n_dbl, 10);
    chk(!busy_o, "R9", "idle after done", busy_o, 0);
    chk(recovered_o == done_rec && error_o == done_err, "R9", "flags held",
        {recovered_o, error_o}, {done_rec, done_err});
    if (oc == OUT_ACK) begin
      chk(n_srst == 0 && n_rest == 0, (ack_after == FRZ_LIMIT) ? "R4" : "R3",
          "no reset path after ack", n_srst + n_rest, 0);
      chk(!done_rec && !done_err, "R3", "flags after ack", {done_rec, done_err}, 0);
    end else if (oc == OUT_REC) begin
      chk(n_srst == 1, "R5", "soft reset writes", n_srst, 1);
      chk(srst_tcnt == FRZ_LIMIT, "R5", "ticks before soft reset", srst_tcnt, FRZ_LIMIT);
      chk(n_rest == 1 && rest_data == cfg, "R6", "restore data", rest_data, cfg);
      chk(done_cyc - srst_cyc == rdur + 2, "R6", "reset to done cycles",
          done_cyc - srst_cyc, rdur + 2);
      chk(done_rec && !done_err, "R6", "flags after recovery", {done_rec, done_err}, 2'b10);
    end else begin
      chk(n_srst == 1 && n_rest == 0, "R7", "no restore on stuck reset", n_rest, 0);
      chk(done_cyc - srst_cyc == RST_LIMIT + 2, "R7", "watchdog cycles",
          done_cyc - srst_cyc, RST_LIMIT + 2);
      chk(!done_rec && done_err, "R7", "flags after abort", {done_rec, done_err}, 2'b01);
    end
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !wr_en_o && !recovered_o && !error_o, "R10", "reset outputs",
        {busy_o, done_o, wr_en_o, recovered_o, error_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !wr_en_o, "R10", "idle after release", {busy_o, wr_en_o}, 0);
    // directed corners
    run_case(1, 1, 5, 0, 3, 3);
    run_case(0, 1, 0, 0, 3, 2);
    run_case(0, 1, FRZ_LIMIT - 1, 0, 3, 2);
    run_case(1, 1, FRZ_LIMIT, 0, 3, 2);
    run_case(1, 0, 0, 0, 1, 2);
    run_case(0, 0, 0, 0, 17, 4);
    run_case(1, 0, 0, 1, 1, 2);
    run_case(0, 1, 9, 0, 2, 3);
    // random mix
    for (int k = 0; k < 16; k++) begin
      bit m = bit'($urandom % 2);
      int kind = $urandom % 3;
      int td = $urandom_range(2, 5);
      int rd = $urandom_range(1, 20);
      if (kind == 0) run_case(m, 1, $urandom_range(0, FRZ_LIMIT), 0, rd, td);
      else if (kind == 1) run_case(m, 0, 0, 0, rd, td);
      else run_case(m, 1, FRZ_LIMIT + 1 + $urandom_range(0, 5), 0, rd, td);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule